// File: doc/BRIEF.md
# Door Position Tracker with Calibration and Trust Control

This block follows the position of a moving door from the pulses of a Hall or optical position sensor. It keeps a saturating up/down count, learns the length of a full run, and learns the far endpoint over several runs. It then marks the count as trusted only while that count can be traced back to a known reference, which is the home limit switch.

Each rising edge of the already synchronized pulse input moves the count by one, in the direction given by `dir_up`. The limit-switch input is synchronized and debounced inside the block. A debounced rising edge at home is the anchor: it zeroes the count. A learn command starts calibration. A run is finished when `motion_cmd` falls.

Several events degrade the stored position:
- A reset or brownout flag moves a trusted position to the untrusted state.
- A missing pulse does the same.
- Too many missing pulses, or an open endpoint that drifts too far from the learned one, raise a request to learn again.

Learned values are only presented at the ports; storing them is left to the surrounding system.

Top module: `pos_calib_top`

## Requirements
- R1: After reset the outputs are as follows: `pos`, `travel_len`, `ep_lo`, `ep_hi` and `miss_cnt` are 0, `trusted`, `at_home` and `relearn_req` are 0, and `cal_state` is 0. The `cal_state` codes are: idle=0, learning the travel=1, learning the endpoints=2, trusted=3, untrusted=4.
- R2: A learn command, accepted in any state, clears the count and enters state 1. When `motion_cmd` then falls, the count is checked. If it is at least MIN_TRAVEL and no missing pulse occurred during the run, the count becomes `travel_len` and the state moves to 2. Otherwise the state returns to 0 and `travel_len` is left unchanged.
- R3: In state 2, every fall of `motion_cmd` with `dir_up`=1 records the count as an endpoint sample, and the first sample is the reference. Each later sample whose absolute distance from the reference exceeds `ep_tol` returns the state to 0 at once. Once the third sample is accepted, the state becomes 3, and `ep_lo`/`ep_hi` hold the smallest and largest of the three samples.
- R4: Each rising edge of `pulse_in` changes `pos` by +1 when `dir_up`=1 and by -1 when `dir_up`=0. The new value is visible after the next clock edge.
- R5: `pos` saturates at 0 when counting down and at 2^POS_W-1 when counting up. It never wraps.
- R6: `reset_flag` moves state 3 to state 4; in states 1 and 2 it aborts learning to state 0. An anchor moves state 4 to state 3, and in every state an anchor zeroes `pos`. `trusted` is 1 exactly in state 3.
- R7: While `motion_cmd` is high, the block first measures the period between two edges. After that, a missing pulse is flagged whenever the cycles since the last edge exceed twice the measured period, and the timing window then restarts. Each miss increments `miss_cnt`, which saturates at its maximum. A miss in state 3 moves the state to 4. `relearn_req` is 1 while `miss_cnt` is at least MISS_LIMIT.
- R8: In state 3, if `motion_cmd` falls with `dir_up`=1 and the count differs from the endpoint reference by more than DRIFT_BOUND, `relearn_req` is set and stays set.
- R9: When an anchor and a pulse edge fall in the same cycle, the anchor wins and `pos` becomes 0. When an anchor and `reset_flag` fall in the same cycle in state 4, the state stays 4.
- R10: A learn command clears `miss_cnt` and the drift request, so `relearn_req` returns to 0.
- R11: `limit_raw` passes through two synchronizing flops. `at_home` changes only after 8 consecutive synchronized samples that disagree with it, so a high pulse of 4 cycles neither sets `at_home` nor zeroes `pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Synchronized position pulse; each rising edge is one count |
| dir_up | input | 1 | Count direction, 1 = up (away from home) |
| limit_raw | input | 1 | Raw home limit switch, 1 = at home |
| motion_cmd | input | 1 | High while motion is commanded; a fall ends a run |
| learn_cmd | input | 1 | One-cycle strobe that starts calibration |
| reset_flag | input | 1 | Reset or brownout indication |
| ep_tol | input | POS_W | Endpoint repeatability tolerance, in counts |
| pos | output | POS_W | Position count |
| travel_len | output | POS_W | Learned full-run count |
| ep_lo | output | POS_W | Smallest accepted endpoint sample |
| ep_hi | output | POS_W | Largest accepted endpoint sample |
| trusted | output | 1 | Position is trusted |
| at_home | output | 1 | Debounced limit switch |
| miss_cnt | output | MISS_W | Missing-pulse count |
| relearn_req | output | 1 | Calibration should be repeated |
| cal_state | output | 3 | Calibration state code |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is re-anchoring and counting, when the debounced home edge coincides with a sensor pulse edge. The second pair is re-anchoring and trust loss, when that home edge coincides with a reset flag. The bench first checks `at_home` on the cycles before and after it rises, to locate the exact cycle in which the anchor takes effect. It then drives the pulse, or the reset flag, in that cycle. The pass criteria are a zero count in the first case and a state that stays untrusted in the second. The tolerance edge (a sample exactly `ep_tol` away, then one count further) and the drift edge are probed the same way, with directed runs.

// File: rtl/pos_calib_pkg.sv
package pos_calib_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_LEARN_RUN  = 3'd1,
    ST_LEARN_ENDS = 3'd2,
    ST_TRUSTED    = 3'd3,
    ST_UNTRUSTED  = 3'd4
  } cal_state_e;
endpackage

// File: rtl/pc_limit_filter.sv
module pc_limit_filter #(
  parameter int STABLE_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic limit_raw,
  output logic lim_db,
  output logic anchor
);
  localparam int CW = (STABLE_N > 1) ? $clog2(STABLE_N) : 1;

  logic          sync1_q, sync2_q, db_q, db_prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= 1'b0;
      sync2_q   <= 1'b0;
      db_q      <= 1'b0;
      db_prev_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      sync1_q   <= limit_raw;
      sync2_q   <= sync1_q;
      db_prev_q <= db_q;
      if (sync2_q == db_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE_N - 1)) begin
        db_q  <= sync2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lim_db = db_q;
  assign anchor = db_q & ~db_prev_q;

  // R11: the filtered level only rises while the synchronized sample is high
  p_db_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_q) |-> sync2_q);
  // R11: an anchor event lasts one cycle
  p_anchor_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    anchor |=> !anchor);
endmodule

// File: rtl/pc_pulse_watch.sv
module pc_pulse_watch #(
  parameter int GAP_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic motion_cmd,
  output logic edge_seen,
  output logic miss
);
  logic [GAP_W-1:0] since_q, period_q;
  logic             prev_q, seen_q, valid_q;
  logic [GAP_W:0]   since_p1, limit2;

  function automatic logic [GAP_W-1:0] inc_sat(input logic [GAP_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign edge_seen = pulse_in & ~prev_q;
  assign since_p1  = {1'b0, since_q} + 1'b1;
  assign limit2    = {period_q, 1'b0};
  assign miss      = motion_cmd & valid_q & ~edge_seen & (since_p1 > limit2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      since_q  <= '0;
      period_q <= '0;
      seen_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      prev_q <= pulse_in;
      if (!motion_cmd) begin
        since_q <= '0;
        seen_q  <= 1'b0;
        valid_q <= 1'b0;
      end else if (edge_seen) begin
        if (seen_q) begin
          period_q <= inc_sat(since_q);
          valid_q  <= 1'b1;
        end
        seen_q  <= 1'b1;
        since_q <= '0;
      end else if (miss) begin
        since_q <= '0;
      end else begin
        since_q <= inc_sat(since_q);
      end
    end
  end

  // R7: a miss is only reported while motion is commanded
  p_miss_motion_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> motion_cmd);
  // R7: the cycle after an edge can never be a miss
  p_no_miss_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !miss);
endmodule

// File: rtl/pc_pos_counter.sv
module pc_pos_counter #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             step_up,
  input  logic             clear,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] TOP = '1;

  function automatic logic [POS_W-1:0] sat_move(input logic [POS_W-1:0] v, input logic up);
    if (up) return (v == TOP) ? v : v + 1'b1;
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (clear)   pos <= '0;
    else if (step_en) pos <= sat_move(pos, step_up);
  end

  // R4: one count per edge, in the commanded direction
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && !clear && pos != TOP) |=> (pos - $past(pos)) == POS_W'(1));
  p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && !clear && pos != '0) |=> ($past(pos) - pos) == POS_W'(1));
  // R5: no wrap at either end
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clear && ((step_up && pos == TOP) || (!step_up && pos == '0))) |=> $stable(pos));
  // R9: clearing dominates stepping
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pos == '0);
endmodule

// File: rtl/pc_calib_fsm.sv
module pc_calib_fsm
  import pos_calib_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int MISS_W      = 8,
  parameter int MIN_TRAVEL  = 16,
  parameter int DRIFT_BOUND = 8,
  parameter int MISS_LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              learn_cmd,
  input  logic              motion_cmd,
  input  logic              dir_up,
  input  logic              reset_flag,
  input  logic              anchor,
  input  logic              miss,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  ep_tol,
  output cal_state_e        state_q,
  output logic [POS_W-1:0]  travel_q,
  output logic [POS_W-1:0]  ep_lo_q,
  output logic [POS_W-1:0]  ep_hi_q,
  output logic [MISS_W-1:0] miss_cnt_q,
  output logic              relearn
);
  localparam logic [MISS_W-1:0] MISS_TOP = '1;

  logic [POS_W-1:0] ep_ref_q;
  logic [1:0]       ep_idx_q;
  logic             run_miss_q, drift_q, motion_q;
  logic             run_end, up_end, travel_ok, drift_hit;

  function automatic logic [POS_W-1:0] absdiff(input logic [POS_W-1:0] a, input logic [POS_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  assign run_end   = motion_q & ~motion_cmd;
  assign up_end    = run_end & dir_up;
  assign travel_ok = (pos >= POS_W'(MIN_TRAVEL)) && !run_miss_q && !miss;
  assign drift_hit = absdiff(pos, ep_ref_q) > POS_W'(DRIFT_BOUND);
  assign relearn   = drift_q | (miss_cnt_q >= MISS_W'(MISS_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      travel_q   <= '0;
      ep_ref_q   <= '0;
      ep_lo_q    <= '0;
      ep_hi_q    <= '0;
      ep_idx_q   <= '0;
      miss_cnt_q <= '0;
      run_miss_q <= 1'b0;
      drift_q    <= 1'b0;
      motion_q   <= 1'b0;
    end else begin
      motion_q <= motion_cmd;
      if (learn_cmd)                         miss_cnt_q <= '0;
      else if (miss && miss_cnt_q != MISS_TOP) miss_cnt_q <= miss_cnt_q + 1'b1;

      if (learn_cmd) begin
        state_q    <= ST_LEARN_RUN;
        run_miss_q <= 1'b0;
        drift_q    <= 1'b0;
        ep_idx_q   <= '0;
      end else if (reset_flag) begin
        if (state_q == ST_TRUSTED) state_q <= ST_UNTRUSTED;
        else if (state_q == ST_LEARN_RUN || state_q == ST_LEARN_ENDS) state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_LEARN_RUN: begin
            if (miss) run_miss_q <= 1'b1;
            if (run_end) begin
              if (travel_ok) begin
                travel_q <= pos;
                ep_idx_q <= '0;
                state_q  <= ST_LEARN_ENDS;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_LEARN_ENDS: begin
            if (up_end) begin
              if (ep_idx_q == 2'd0) begin
                ep_ref_q <= pos;
                ep_lo_q  <= pos;
                ep_hi_q  <= pos;
                ep_idx_q <= 2'd1;
              end else if (absdiff(pos, ep_ref_q) > ep_tol) begin
                state_q <= ST_IDLE;
              end else begin
                if (pos < ep_lo_q) ep_lo_q <= pos;
                if (pos > ep_hi_q) ep_hi_q <= pos;
                if (ep_idx_q == 2'd2) state_q <= ST_TRUSTED;
                else                  ep_idx_q <= ep_idx_q + 1'b1;
              end
            end
          end
          ST_TRUSTED: begin
            if (miss)                        state_q <= ST_UNTRUSTED;
            else if (up_end && drift_hit)    drift_q <= 1'b1;
          end
          ST_UNTRUSTED: begin
            if (anchor) state_q <= ST_TRUSTED;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: trust loss and recovery
  p_trust_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRUSTED && reset_flag && !learn_cmd) |=> state_q == ST_UNTRUSTED);
  p_reanchor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNTRUSTED && anchor && !reset_flag && !learn_cmd) |=> state_q == ST_TRUSTED);
  // R9: reset indication dominates a simultaneous anchor
  p_reset_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNTRUSTED && anchor && reset_flag && !learn_cmd) |=> state_q == ST_UNTRUSTED);
  // R7: a miss while trusted downgrades
  p_miss_downgrade_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRUSTED && miss && !reset_flag && !learn_cmd) |=> state_q == ST_UNTRUSTED);
  // R10: learn command clears the request sources
  p_learn_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    learn_cmd |=> (miss_cnt_q == '0 && !drift_q && state_q == ST_LEARN_RUN));
  // R3: accepted endpoints are ordered
  p_ep_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRUSTED) |-> ep_lo_q <= ep_hi_q);
endmodule

// File: rtl/pos_calib_top.sv
module pos_calib_top
  import pos_calib_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int MISS_W      = 8,
  parameter int GAP_W       = 16,
  parameter int STABLE_N    = 8,
  parameter int MIN_TRAVEL  = 16,
  parameter int DRIFT_BOUND = 8,
  parameter int MISS_LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_in,
  input  logic              dir_up,
  input  logic              limit_raw,
  input  logic              motion_cmd,
  input  logic              learn_cmd,
  input  logic              reset_flag,
  input  logic [POS_W-1:0]  ep_tol,
  output logic [POS_W-1:0]  pos,
  output logic [POS_W-1:0]  travel_len,
  output logic [POS_W-1:0]  ep_lo,
  output logic [POS_W-1:0]  ep_hi,
  output logic              trusted,
  output logic              at_home,
  output logic [MISS_W-1:0] miss_cnt,
  output logic              relearn_req,
  output logic [2:0]        cal_state
);
  logic       edge_seen, miss, anchor, pos_clear;
  cal_state_e state;

  pc_limit_filter #(.STABLE_N(STABLE_N)) u_lim (
    .clk(clk), .rst_n(rst_n), .limit_raw(limit_raw),
    .lim_db(at_home), .anchor(anchor));

  pc_pulse_watch #(.GAP_W(GAP_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .motion_cmd(motion_cmd),
    .edge_seen(edge_seen), .miss(miss));

  assign pos_clear = anchor | learn_cmd;

  pc_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(edge_seen), .step_up(dir_up),
    .clear(pos_clear), .pos(pos));

  pc_calib_fsm #(
    .POS_W(POS_W), .MISS_W(MISS_W), .MIN_TRAVEL(MIN_TRAVEL),
    .DRIFT_BOUND(DRIFT_BOUND), .MISS_LIMIT(MISS_LIMIT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .learn_cmd(learn_cmd), .motion_cmd(motion_cmd),
    .dir_up(dir_up), .reset_flag(reset_flag), .anchor(anchor), .miss(miss),
    .pos(pos), .ep_tol(ep_tol), .state_q(state), .travel_q(travel_len),
    .ep_lo_q(ep_lo), .ep_hi_q(ep_hi), .miss_cnt_q(miss_cnt), .relearn(relearn_req));

  assign cal_state = state;
  assign trusted   = (state == ST_TRUSTED);

  // R6: trusted output only while re-anchored and not faulted
  p_trusted_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trusted && !miss && !reset_flag && !learn_cmd) |=> trusted);
  // R9: anchor beats a simultaneous count edge at the ports
  p_anchor_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (anchor && edge_seen) |=> pos == '0);
endmodule

// File: tb/pos_calib_top_tb_top.sv
`timescale 1ns/1ps
module pos_calib_top_tb_top;
  localparam int PW = 10;
  localparam int MW = 8;
  localparam int TOPV = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 0, dir_up = 0, limit_raw = 0, motion_cmd = 0, learn_cmd = 0, reset_flag = 0;
  logic [PW-1:0] ep_tol = PW'(4);
  logic [PW-1:0] pos, travel_len, ep_lo, ep_hi;
  logic trusted, at_home, relearn_req;
  logic [MW-1:0] miss_cnt;
  logic [2:0] cal_state;

  int total = 0, bad = 0, exp_pos = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pos_calib_top #(.POS_W(PW), .MISS_W(MW), .GAP_W(16), .STABLE_N(8),
    .MIN_TRAVEL(16), .DRIFT_BOUND(8), .MISS_LIMIT(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .dir_up(dir_up),
    .limit_raw(limit_raw), .motion_cmd(motion_cmd), .learn_cmd(learn_cmd),
    .reset_flag(reset_flag), .ep_tol(ep_tol), .pos(pos), .travel_len(travel_len),
    .ep_lo(ep_lo), .ep_hi(ep_hi), .trusted(trusted), .at_home(at_home),
    .miss_cnt(miss_cnt), .relearn_req(relearn_req), .cal_state(cal_state));

  function automatic int model_move(int p, bit up, int n);
    int r = up ? p + n : p - n;
    if (r > TOPV) r = TOPV;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1;
      @(negedge clk);
      pulse_in = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic run_seg(int n, bit up, bit end_up);
    @(negedge clk);
    motion_cmd = 1'b1;
    dir_up = up;
    pulses(n);
    motion_cmd = 1'b0;
    dir_up = end_up;
    repeat (2) @(negedge clk);
    exp_pos = model_move(exp_pos, up, n);
  endtask

  task automatic go_home();
    @(negedge clk);
    limit_raw = 1'b1;
    repeat (14) @(negedge clk);
    limit_raw = 1'b0;
    repeat (14) @(negedge clk);
    exp_pos = 0;
  endtask

  task automatic learn();
    @(negedge clk);
    learn_cmd = 1'b1;
    @(negedge clk);
    learn_cmd = 1'b0;
    exp_pos = 0;
  endtask

  task automatic full_learn(int s1, int s2, int s3);
    learn();
    run_seg(100, 1, 1);
    go_home(); run_seg(s1, 1, 1);
    go_home(); run_seg(s2, 1, 1);
    go_home(); run_seg(s3, 1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog (all R) actual=%0d cycles expected=finish", 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pos", int'(pos), 0);
    check("R1 travel", int'(travel_len), 0);
    check("R1 state", int'(cal_state), 0);
    check("R1 flags", int'({trusted, at_home, relearn_req}), 0);
    check("R1 miss", int'(miss_cnt), 0);

    // R2 short run rejected
    learn();
    check("R2 enter learn", int'(cal_state), 1);
    run_seg(5, 1, 1);
    check("R2 short state", int'(cal_state), 0);
    check("R2 short travel", int'(travel_len), 0);
    // R2 valid run
    learn();
    run_seg(100, 1, 1);
    check("R2 travel", int'(travel_len), 100);
    check("R2 state", int'(cal_state), 2);
    // R3 sample one past tolerance rejected
    go_home(); run_seg(100, 1, 1);
    go_home(); run_seg(105, 1, 1);
    check("R3 reject", int'(cal_state), 0);
    // R3 accept, boundary at exact tolerance
    learn();
    run_seg(100, 1, 1);
    go_home(); run_seg(100, 1, 1);
    go_home(); run_seg(104, 1, 1);
    check("R3 boundary kept", int'(cal_state), 2);
    go_home(); run_seg(97, 1, 1);
    check("R3 trusted state", int'(cal_state), 3);
    check("R6 trusted flag", int'(trusted), 1);
    check("R3 ep_lo", int'(ep_lo), 97);
    check("R3 ep_hi", int'(ep_hi), 104);

    // R4 random up/down segments
    for (int k = 0; k < 8; k++) begin
      bit up = 1'($urandom_range(0, 1));
      int n = int'($urandom_range(1, 40));
      run_seg(n, up, 0);
      check("R4 random pos", int'(pos), exp_pos);
    end
    // R5 top saturation
    run_seg(1100, 1, 0);
    check("R5 top", int'(pos), TOPV);
    // R11 short limit glitch ignored
    @(negedge clk); limit_raw = 1'b1;
    repeat (4) @(negedge clk); limit_raw = 1'b0;
    repeat (15) @(negedge clk);
    check("R11 glitch pos", int'(pos), TOPV);
    check("R11 glitch home", int'(at_home), 0);
    // R5 bottom saturation
    run_seg(1030, 0, 0);
    check("R5 bottom", int'(pos), 0);

    // R6 anchor zeroes while trusted
    run_seg(30, 1, 0);
    go_home();
    check("R6 anchor pos", int'(pos), 0);
    check("R6 still trusted", int'(cal_state), 3);

    // R7 one missing pulse
    @(negedge clk); motion_cmd = 1'b1; dir_up = 1'b1;
    pulses(5);
    repeat (8) @(negedge clk);
    motion_cmd = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 miss count", int'(miss_cnt), 1);
    check("R7 downgrade", int'(cal_state), 4);
    check("R7 no request", int'(relearn_req), 0);

    // R6 re-anchor then reset flag
    go_home();
    check("R6 reanchor", int'(cal_state), 3);
    @(negedge clk); reset_flag = 1'b1;
    @(negedge clk); reset_flag = 1'b0;
    @(negedge clk);
    check("R6 reset flag", int'(cal_state), 4);
    check("R6 trusted low", int'(trusted), 0);

    // R9 anchor and reset flag in the same cycle
    run_seg(6, 1, 0);
    @(negedge clk); limit_raw = 1'b1;
    repeat (9) @(posedge clk);
    @(negedge clk);
    check("R9 home before", int'(at_home), 0);
    @(negedge clk);
    check("R9 home now", int'(at_home), 1);
    reset_flag = 1'b1;
    @(negedge clk); reset_flag = 1'b0;
    @(negedge clk);
    check("R9 reset wins", int'(cal_state), 4);
    check("R9 pos zeroed", int'(pos), 0);
    limit_raw = 1'b0;
    repeat (14) @(negedge clk);
    // R9 anchor and pulse edge in the same cycle
    run_seg(7, 1, 0);
    check("R4 pos before", int'(pos), 7);
    @(negedge clk); limit_raw = 1'b1; dir_up = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    pulse_in = 1'b1;
    @(negedge clk); pulse_in = 1'b0;
    @(negedge clk);
    check("R9 anchor beats pulse", int'(pos), 0);
    check("R9 retrusted", int'(cal_state), 3);
    limit_raw = 1'b0; dir_up = 1'b0;
    repeat (14) @(negedge clk);

    // R7 miss limit raises request
    @(negedge clk); motion_cmd = 1'b1; dir_up = 1'b1;
    pulses(4);
    repeat (17) @(negedge clk);
    motion_cmd = 1'b0; dir_up = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 miss total", int'(miss_cnt), 3);
    check("R7 request", int'(relearn_req), 1);

    // R10 learn clears
    learn();
    check("R10 miss cleared", int'(miss_cnt), 0);
    check("R10 request cleared", int'(relearn_req), 0);
    check("R10 state", int'(cal_state), 1);

    // R8 drift bound
    run_seg(100, 1, 1);
    go_home(); run_seg(100, 1, 1);
    go_home(); run_seg(100, 1, 1);
    go_home(); run_seg(100, 1, 1);
    check("R8 trusted", int'(cal_state), 3);
    go_home(); run_seg(108, 1, 1);
    check("R8 at bound", int'(relearn_req), 0);
    go_home(); run_seg(109, 1, 1);
    check("R8 past bound", int'(relearn_req), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule